// File: doc/BRIEF.md
# CPU Address Decode Window Unit

This block decides where each CPU bus address goes. It holds eight programmable windows. Each window is described by a base, a size mask with 64 KB granularity, a target interface code, an attribute byte and an enable bit. When a lookup address falls inside an enabled window, the block reports a hit together with that window's target and attribute. It also returns a translated address, which differs from the input only on the lowest windows, the ones that carry remap registers.

Software programs the windows through a word-addressed register port. Every window owns four 32-bit registers in a 16-byte slot: control, base, remap-low and remap-high. The decode logic works on the registered configuration. The result is registered once, so a lookup presented in one cycle is answered after the next clock edge.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every register reads 0 and every window is disabled, so any valid lookup reports no hit.
- R2: The register at byte offset 16*w + 4*k (word address cfg_word = 4*w + k) is control for k=0, base for k=1, remap-low for k=2 and remap-high for k=3. Control keeps bits 31:16 (size minus one, in 64 KB units), 15:8 (attribute), 7:4 (target) and 0 (enable), and reads 0 in bits 3:1. Base and remap-low keep only bits 31:16. Remap-high keeps all 32 bits. Read data appears one cycle after the request.
- R3: An access whose window index cfg_word[5:2] is 8 or more raises cfg_err in the next cycle, writes nothing and returns read data 0.
- R4: Windows with an index at or above NUM_REMAP (default 2) have no remap registers. Writes to their remap-low and remap-high registers are ignored, and reads of those registers return 0.
- R5: A window hits when it is enabled and (addr[31:16] & ~size_mask) equals (base[31:16] & ~size_mask).
- R6: A window with its enable bit clear never hits, whatever its other fields hold.
- R7: When several windows hit, the lowest-numbered one supplies the target, the attribute and the translation.
- R8: A valid lookup that hits no window gives lk_miss=1 and lk_hit=0, with target 4'hF, attribute 0 and both address outputs 0. Hit and miss are never high together.
- R9: On a hit in a remap-capable window, lk_xaddr is {remap_low[31:16], addr[15:0]} and lk_xaddr_hi is that window's remap-high register. On a hit in any other window, lk_xaddr equals the input address and lk_xaddr_hi is 0.
- R10: Lookup results appear one cycle after lk_addr is presented. A register write becomes effective for a lookup presented in the cycle after the write.
- R11: When lk_valid is low, both lk_hit and lk_miss are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_req | input | 1 | Register access request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_word | input | 6 | Word address: window in [5:2], register in [1:0] |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after the request |
| cfg_err | output | 1 | Access addressed a window index of 8 or more |
| lk_valid | input | 1 | Lookup address is valid |
| lk_addr | input | 32 | CPU address to decode |
| lk_hit | output | 1 | A window matched |
| lk_miss | output | 1 | Valid lookup with no matching window |
| lk_tgt | output | 4 | Target interface code, 4'hF on miss |
| lk_attr | output | 8 | Attribute byte of the winning window |
| lk_xaddr | output | 32 | Translated address, low 32 bits |
| lk_xaddr_hi | output | 32 | Upper address bits from remap-high |

## Verification
The hardest case to reach is a lookup hit by two enabled windows at once, where the lower window is also remap-capable. In that case priority and translation must both pick the same window. The bench builds this from the register port: it programs a wide non-remap window and a narrower remap window nested inside it. It then probes one address inside both windows and one address inside only the wide window. The bench also programs a window, disables it and probes it again, which shows that the enable bit alone gates the match.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_W   = 16;
    localparam int WORD_W   = 6;
    localparam logic [3:0] TGT_NONE = 4'hF;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_BASE  = 2'd1,
        REG_RMLO  = 2'd2,
        REG_RMHI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PAGE_W-1:0] mask;
        logic [7:0]        attr;
        logic [3:0]        tgt;
        logic              en;
    } win_ctrl_t;

    typedef struct packed {
        logic              hit;
        logic              miss;
        logic [3:0]        tgt;
        logic [7:0]        attr;
        logic [ADDR_W-1:0] xaddr;
        logic [ADDR_W-1:0] xhi;
    } lk_out_t;

endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_req,
    input  logic                                cfg_wr,
    input  logic [WORD_W-1:0]                   cfg_word,
    input  logic [ADDR_W-1:0]                   cfg_wdata,
    output logic [ADDR_W-1:0]                   cfg_rdata,
    output logic                                cfg_err,
    output win_ctrl_t [NUM_WIN-1:0]             ctrl_o,
    output logic [NUM_WIN-1:0][PAGE_W-1:0]      base_o,
    output logic [NUM_WIN-1:0][PAGE_W-1:0]      rmlo_o,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]      rmhi_o
);

    localparam int IDX_W = WORD_W - 2;

    typedef struct packed {
        win_ctrl_t [NUM_WIN-1:0]        ctrl;
        logic [NUM_WIN-1:0][PAGE_W-1:0] base;
        logic [NUM_WIN-1:0][PAGE_W-1:0] rmlo;
        logic [NUM_WIN-1:0][ADDR_W-1:0] rmhi;
        logic [ADDR_W-1:0]              rdata;
        logic                           err;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] idx;
    reg_sel_e         sel;
    logic             in_range;

    assign idx      = cfg_word[WORD_W-1:2];
    assign sel      = reg_sel_e'(cfg_word[1:0]);
    assign in_range = (int'(idx) < NUM_WIN);

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        r_d.rdata = '0;
        if (cfg_req) begin
            r_d.err = !in_range;
            for (int w = 0; w < NUM_WIN; w++) begin
                if (in_range && idx == IDX_W'(w)) begin
                    // read returns the value held before a same-cycle write
                    unique case (sel)
                        REG_CTRL: r_d.rdata = {r_q.ctrl[w].mask, r_q.ctrl[w].attr,
                                               r_q.ctrl[w].tgt, 3'b000, r_q.ctrl[w].en};
                        REG_BASE: r_d.rdata = {r_q.base[w], {PAGE_W{1'b0}}};
                        REG_RMLO: r_d.rdata = (w < NUM_REMAP) ?
                                              {r_q.rmlo[w], {PAGE_W{1'b0}}} : '0;
                        REG_RMHI: r_d.rdata = (w < NUM_REMAP) ? r_q.rmhi[w] : '0;
                    endcase
                    if (!cfg_wr) begin
                        // rdata already set above
                    end else begin
                        r_d.rdata = '0;
                        unique case (sel)
                            REG_CTRL: begin
                                r_d.ctrl[w].mask = cfg_wdata[31:16];
                                r_d.ctrl[w].attr = cfg_wdata[15:8];
                                r_d.ctrl[w].tgt  = cfg_wdata[7:4];
                                r_d.ctrl[w].en   = cfg_wdata[0];
                            end
                            REG_BASE: r_d.base[w] = cfg_wdata[31:16];
                            REG_RMLO: if (w < NUM_REMAP) r_d.rmlo[w] = cfg_wdata[31:16];
                            REG_RMHI: if (w < NUM_REMAP) r_d.rmhi[w] = cfg_wdata;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_rdata = r_q.rdata;
    assign cfg_err   = r_q.err;
    assign ctrl_o    = r_q.ctrl;
    assign base_o    = r_q.base;
    assign rmlo_o    = r_q.rmlo;
    assign rmhi_o    = r_q.rmhi;

endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
    import addr_win_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] mask,
    input  logic [PAGE_W-1:0] base,
    input  logic              en,
    output logic              hit
);

    always_comb begin
        hit = en && ((page & ~mask) == (base & ~mask));
    end

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic [5:0]        cfg_word,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_err,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [3:0]        lk_tgt,
    output logic [7:0]        lk_attr,
    output logic [31:0]       lk_xaddr,
    output logic [31:0]       lk_xaddr_hi
);

    win_ctrl_t [NUM_WIN-1:0]        ctrl;
    logic [NUM_WIN-1:0][PAGE_W-1:0] base;
    logic [NUM_WIN-1:0][PAGE_W-1:0] rmlo;
    logic [NUM_WIN-1:0][ADDR_W-1:0] rmhi;
    logic [NUM_WIN-1:0]             win_hit;

    addr_win_regs #(
        .NUM_WIN   (NUM_WIN),
        .NUM_REMAP (NUM_REMAP)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_req   (cfg_req),
        .cfg_wr    (cfg_wr),
        .cfg_word  (cfg_word),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .ctrl_o    (ctrl),
        .base_o    (base),
        .rmlo_o    (rmlo),
        .rmhi_o    (rmhi)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        addr_win_match u_match (
            .page (lk_addr[ADDR_W-1:PAGE_W]),
            .mask (ctrl[g].mask),
            .base (base[g]),
            .en   (ctrl[g].en),
            .hit  (win_hit[g])
        );
    end

    lk_out_t out_d, out_q;
    logic    found;

    always_comb begin
        out_d     = '0;
        out_d.tgt = TGT_NONE;
        found     = 1'b0;
        if (lk_valid) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (!found && win_hit[w]) begin
                    found      = 1'b1;
                    out_d.tgt  = ctrl[w].tgt;
                    out_d.attr = ctrl[w].attr;
                    if (w < NUM_REMAP) begin
                        out_d.xaddr = {rmlo[w], lk_addr[PAGE_W-1:0]};
                        out_d.xhi   = rmhi[w];
                    end else begin
                        out_d.xaddr = lk_addr;
                    end
                end
            end
            out_d.hit  = found;
            out_d.miss = !found;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{hit: 1'b0, miss: 1'b0, tgt: TGT_NONE, attr: '0,
                               xaddr: '0, xhi: '0};
        else        out_q <= out_d;
    end

    assign lk_hit      = out_q.hit;
    assign lk_miss     = out_q.miss;
    assign lk_tgt      = out_q.tgt;
    assign lk_attr     = out_q.attr;
    assign lk_xaddr    = out_q.xaddr;
    assign lk_xaddr_hi = out_q.xhi;

endmodule

// File: rtl/addr_win_checker.sv
module addr_win_checker #(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_req,
    input logic        cfg_wr,
    input logic [5:0]  cfg_word,
    input logic [31:0] cfg_rdata,
    input logic        cfg_err,
    input logic        lk_valid,
    input logic [31:0] lk_addr,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic [3:0]  lk_tgt,
    input logic [7:0]  lk_attr,
    input logic [31:0] lk_xaddr,
    input logic [31:0] lk_xaddr_hi
);

    logic bad_idx, rd_remap_absent, rd_ctrl;
    assign bad_idx         = cfg_req && (int'(cfg_word[5:2]) >= NUM_WIN);
    assign rd_remap_absent = cfg_req && !cfg_wr && cfg_word[1]
                             && (int'(cfg_word[5:2]) >= NUM_REMAP);
    assign rd_ctrl         = cfg_req && !cfg_wr && (cfg_word[1:0] == 2'd0);

    a_r3_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bad_idx |=> cfg_err);

    a_r3_err_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cfg_rdata == 32'h0);

    a_r4_no_remap_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_remap_absent |=> cfg_rdata == 32'h0);

    a_r2_ctrl_gap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |=> cfg_rdata[3:1] == 3'b000);

    a_r8_miss_out: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_tgt == 4'hF && lk_attr == 8'h0
                     && lk_xaddr == 32'h0 && lk_xaddr_hi == 32'h0));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && !lk_miss));

    a_r9_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!lk_hit || lk_xaddr[15:0] == $past(lk_addr[15:0])));

endmodule

bind addr_win_decoder addr_win_checker #(
    .NUM_WIN   (NUM_WIN),
    .NUM_REMAP (NUM_REMAP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_req     (cfg_req),
    .cfg_wr      (cfg_wr),
    .cfg_word    (cfg_word),
    .cfg_rdata   (cfg_rdata),
    .cfg_err     (cfg_err),
    .lk_valid    (lk_valid),
    .lk_addr     (lk_addr),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_tgt      (lk_tgt),
    .lk_attr     (lk_attr),
    .lk_xaddr    (lk_xaddr),
    .lk_xaddr_hi (lk_xaddr_hi)
);

// File: tb/test_addr_win_decoder.sv
`timescale 1ns/1ps
module test_addr_win_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_word = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_hit, lk_miss;
    logic [3:0]  lk_tgt;
    logic [7:0]  lk_attr;
    logic [31:0] lk_xaddr, lk_xaddr_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addr_win_decoder i_addr_win_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_tgt(lk_tgt), .lk_attr(lk_attr),
        .lk_xaddr(lk_xaddr), .lk_xaddr_hi(lk_xaddr_hi)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [5:0] w_of(int win, int k);
        return 6'(win * 4 + k);
    endfunction

    task automatic cfg_write(logic [5:0] word, logic [31:0] data, output logic err);
        @(negedge clk);
        cfg_req = 1'b1; cfg_wr = 1'b1; cfg_word = word; cfg_wdata = data;
        @(negedge clk);
        err = cfg_err;
        cfg_req = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(logic [5:0] word, output logic [31:0] data, output logic err);
        @(negedge clk);
        cfg_req = 1'b1; cfg_wr = 1'b0; cfg_word = word;
        @(negedge clk);
        data = cfg_rdata; err = cfg_err;
        cfg_req = 1'b0;
    endtask

    task automatic look(logic [31:0] a, logic v, string req,
                        logic eh, logic em, logic [3:0] et, logic [7:0] ea,
                        logic [31:0] ex, logic [31:0] exh);
        @(negedge clk);
        lk_valid = v; lk_addr = a;
        @(negedge clk);
        chk({req, " hit"},  32'(lk_hit),  32'(eh));
        chk({req, " miss"}, 32'(lk_miss), 32'(em));
        chk({req, " tgt"},  32'(lk_tgt),  32'(et));
        chk({req, " attr"}, 32'(lk_attr), 32'(ea));
        chk({req, " xaddr"}, lk_xaddr, ex);
        chk({req, " xhi"},  lk_xaddr_hi, exh);
        lk_valid = 1'b0;
    endtask

    task automatic wr(int win, int k, logic [31:0] d);
        logic e;
        cfg_write(w_of(win, k), d, e);
        chk("R3 in-range write err", 32'(e), 32'h0);
    endtask

    task automatic rd_chk(int win, int k, logic [31:0] exp, string req);
        logic [31:0] d; logic e;
        cfg_read(w_of(win, k), d, e);
        chk(req, d, exp);
    endtask

    // R1: reset state
    task automatic t_reset();
        for (int w = 0; w < 8; w++) rd_chk(w, 0, 32'h0, "R1 ctrl after reset");
        rd_chk(0, 3, 32'h0, "R1 remap-high after reset");
        look(32'h0000_0000, 1'b1, "R1 lookup after reset", 0, 1, 4'hF, 0, 0, 0);
    endtask

    // R2: register layout and field masks
    task automatic t_regmap();
        wr(3, 0, 32'hFFFF_FFFF);
        rd_chk(3, 0, 32'hFFFF_FFF1, "R2 ctrl fields");
        wr(3, 1, 32'hFFFF_FFFF);
        rd_chk(3, 1, 32'hFFFF_0000, "R2 base page only");
        wr(0, 3, 32'h1234_5678);
        rd_chk(0, 3, 32'h1234_5678, "R2 remap-high full");
        wr(1, 2, 32'hABCD_1234);
        rd_chk(1, 2, 32'hABCD_0000, "R2 remap-low page only");
        wr(3, 0, 32'h0);
        wr(3, 1, 32'h0);
    endtask

    // R3: out-of-range window index
    task automatic t_bad_index();
        logic e; logic [31:0] d;
        cfg_write(6'h20, 32'h0000_0011, e);
        chk("R3 err on write to window 8", 32'(e), 32'h1);
        cfg_read(6'h3C, d, e);
        chk("R3 err on read of window 15", 32'(e), 32'h1);
        chk("R3 rdata zero on error", d, 32'h0);
        look(32'h0000_1234, 1'b1, "R3 write ignored", 0, 1, 4'hF, 0, 0, 0);
    endtask

    // R4: remap registers missing on upper windows
    task automatic t_remap_absent();
        wr(2, 2, 32'hFFFF_0000);
        rd_chk(2, 2, 32'h0, "R4 remap-low absent on window 2");
        wr(7, 3, 32'hDEAD_BEEF);
        rd_chk(7, 3, 32'h0, "R4 remap-high absent on window 7");
    endtask

    // R5/R9: plain hit on a non-remap window, R10 timing
    task automatic t_basic_hit();
        wr(4, 1, 32'h1000_0000);
        wr(4, 0, 32'h00FF_5941);
        look(32'h10AB_CDEF, 1'b1, "R5 R9 R10 hit window 4", 1, 0, 4'h4, 8'h59,
             32'h10AB_CDEF, 0);
        look(32'h1100_0000, 1'b1, "R5 just outside window 4", 0, 1, 4'hF, 0, 0, 0);
    endtask

    // R6: enable gates the match
    task automatic t_disable();
        wr(4, 0, 32'h00FF_5940);
        look(32'h10AB_CDEF, 1'b1, "R6 disabled window", 0, 1, 4'hF, 0, 0, 0);
        wr(4, 0, 32'h00FF_5941);
    endtask

    // R7: overlapping windows, lower index wins (and it remaps)
    task automatic t_priority();
        wr(1, 1, 32'h1080_0000);
        wr(1, 0, 32'h007F_5131);
        look(32'h10AB_CDEF, 1'b1, "R7 R9 overlap picks window 1", 1, 0, 4'h3, 8'h51,
             32'hABCD_CDEF, 0);
        look(32'h1000_0000, 1'b1, "R7 only window 4", 1, 0, 4'h4, 8'h59,
             32'h1000_0000, 0);
    endtask

    // R9/R8: translation with remap-high on window 0, and 64 KB boundary
    task automatic t_translate();
        wr(0, 1, 32'hF000_0000);
        wr(0, 2, 32'h0002_0000);
        wr(0, 0, 32'h0000_0F11);
        look(32'hF000_1234, 1'b1, "R9 remap window 0", 1, 0, 4'h1, 8'h0F,
             32'h0002_1234, 32'h1234_5678);
        look(32'hF001_0000, 1'b1, "R8 miss beyond 64KB", 0, 1, 4'hF, 0, 0, 0);
    endtask

    // R11: invalid lookup
    task automatic t_idle();
        look(32'hF000_1234, 1'b0, "R11 idle lookup", 0, 0, 4'hF, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_bad_index();
        t_remap_absent();
        t_basic_hit();
        t_disable();
        t_priority();
        t_translate();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule